// File: doc/BRIEF.md
# Byte-Accessed 16-bit Timer with Capture

This block is a 16-bit up-counting timer reached through a small 8-bit register bus. Software sees the count as two byte registers (high and low), a 16-bit reload value split the same way, a control byte and a 16-bit capture value. A power-of-two prescaler divides the system clock before the counter, so one count step lasts 1, 2, 4 and so on up to 128 system clocks.

In continuous mode the counter climbs from 0x0001. When it equals the reload value, the next step returns it to 0x0001, flips the timer output and raises a one-clock interrupt pulse. In capture mode the counter sits idle until the first active edge of the external timer input. That edge starts counting and raises no interrupt. Each later active edge copies the count into the capture register and raises the interrupt. A reload match in this mode behaves as it does in continuous mode.

While the timer runs, a read of the high count byte stores the low byte in a shadow latch. A later read of the low byte returns that latch, so software always gets a coherent 16-bit value. Byte writes to the count go straight into the live counter at the next clock edge. Nothing buffers them.

Top module: `tmr16_top`

## Requirements
- R1: After reset the count reads 0x0001, the reload reads 0xFFFF, the control byte and the capture value read 0x00, and the timer output and interrupt are low. The bus addresses are: 0 count high, 1 count low, 2 reload high, 3 reload low, 4 control, 5 capture high, 6 capture low.
- R2: While control bit 0 (run) is clear, the counter holds its value. A read of address 1 returns the live low byte of the counter.
- R3: While the timer runs, a read of address 0 copies the live low count byte into a shadow latch. A read of address 1 then returns the shadow latch, not the live low byte.
- R4: Reads never alter counting. The count sequence seen after any reads matches the one expected with no reads.
- R5: A write to address 0 or 1, with the timer running or stopped, replaces that byte of the counter at the write's clock edge. Counting then continues from the new value, and the other byte is left as it was.
- R6: Control bits 4:2 select the prescale exponent e. The counter advances once every 2^e clocks, and the prescaler restarts from zero whenever the timer is stopped.
- R7: In continuous mode (control bit 1 clear), a step taken while the count equals the reload value loads 0x0001. Starting from 0x0001 with reload N, interrupts occur every N*2^e clocks, and the first one comes N*2^e clocks after the enabling write.
- R8: The timer output toggles on every reload and at no other time. The interrupt is a single-clock pulse.
- R9: In capture mode (control bit 1 set), the counter does not advance before the first active input edge. That edge starts counting and raises no interrupt.
- R10: In capture mode, each later active edge stores the pre-edge count into the capture register and pulses the interrupt. Control bit 5 selects the active edge: 0 for rising, 1 for falling. With a prescale of 1, the captured value equals the number of clocks between the starting edge and the capturing edge.
- R11: In capture mode, a reload match also loads 0x0001, toggles the output and pulses the interrupt. The input passes through two synchronizer flops and one edge flop, so with a prescale of 1, a count of 1 and reload N, the reload pulse appears N+3 clocks after the start edge is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_rd | input | 1 | Read strobe, one clock per read (drives shadow capture) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| tmr_in | input | 1 | External timer input (asynchronous) |
| tmr_out | output | 1 | Timer output, toggles on reload |
| tmr_irq | output | 1 | Interrupt pulse, one clock |

## Verification
The bench starts the high-byte read just before the low count byte wraps from 0xFF to 0x00. A design without the shadow latch would then return a torn value that jumps by 256. Random reload and prescale pairs check the interrupt period exactly. A prescaler that is not cleared on stop, or a reload that goes to zero instead of one, would shift that period by a clock or more. In capture mode the bench checks that the starting edge gives no interrupt, that inactive edges are ignored in both polarities, and that the captured values land on the exact cycle distance. An extra synchronizer stage, or an increment on the starting edge, would put those values off by one.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

  typedef enum logic [2:0] {
    A_CNT_HI = 3'd0,
    A_CNT_LO = 3'd1,
    A_RLD_HI = 3'd2,
    A_RLD_LO = 3'd3,
    A_CTRL   = 3'd4,
    A_CAP_HI = 3'd5,
    A_CAP_LO = 3'd6
  } reg_addr_e;

  localparam int CTL_RUN = 0;
  localparam int CTL_CAP = 1;
  localparam int CTL_PS  = 2;

endpackage

// File: rtl/tmr16_prescaler.sv
module tmr16_prescaler #(
  parameter int PSW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic [PSW-1:0] ps_sel,
  output logic           tick
);
  localparam int PCW = (1 << PSW) - 1;

  logic [PCW-1:0] pcnt_q;
  logic [PCW-1:0] limit;

  always_comb begin
    limit = (PCW'(1) << ps_sel) - PCW'(1);
    tick  = run && (pcnt_q == limit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pcnt_q <= '0;
    else if (!run)     pcnt_q <= '0;
    else if (tick)     pcnt_q <= '0;
    else               pcnt_q <= pcnt_q + PCW'(1);
  end
endmodule

// File: rtl/tmr16_edge_det.sv
module tmr16_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic falling,
  output logic act_edge
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              cur;

  assign cur = sync_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      prev_q <= cur;
    end
  end

  always_comb begin
    if (falling) act_edge = prev_q && !cur;
    else         act_edge = cur && !prev_q;
  end
endmodule

// File: rtl/tmr16_core.sv
module tmr16_core #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          cap_mode,
  input  logic          tick,
  input  logic          act_edge,
  input  logic          wr_hi,
  input  logic          wr_lo,
  input  logic [CW/2-1:0] wdata,
  input  logic [CW-1:0] reload,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] cap_o,
  output logic          started_o,
  output logic          count_en,
  output logic          tout,
  output logic          irq
);
  localparam int HB = CW / 2;
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q, cap_q;
  logic          started_q, tout_q, irq_q;
  logic          wr_any, rld_evt, cap_evt;

  always_comb begin
    count_en = run && (!cap_mode || started_q);
    wr_any   = wr_hi || wr_lo;
    rld_evt  = tick && (cnt_q == reload) && !wr_any;
    cap_evt  = run && cap_mode && started_q && act_edge;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 started_q <= 1'b0;
    else if (!run || !cap_mode) started_q <= 1'b0;
    else if (act_edge)          started_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= ONE;
    end else if (wr_any) begin
      if (wr_hi) cnt_q[CW-1:HB] <= wdata;
      if (wr_lo) cnt_q[HB-1:0]  <= wdata;
    end else if (tick) begin
      cnt_q <= rld_evt ? ONE : cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= '0;
      tout_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (cap_evt) cap_q <= cnt_q;
      if (rld_evt) tout_q <= !tout_q;
      irq_q <= rld_evt || cap_evt;
    end
  end

  assign cnt_o     = cnt_q;
  assign cap_o     = cap_q;
  assign started_o = started_q;
  assign tout      = tout_q;
  assign irq       = irq_q;
endmodule

// File: rtl/tmr16_top.sv
module tmr16_top
  import tmr16_pkg::*;
#(
  parameter int CW   = 16,
  parameter int DW   = 8,
  parameter int AW   = 3,
  parameter int PSW  = 3,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          tmr_in,
  output logic          tmr_out,
  output logic          tmr_irq
);
  localparam int HB       = CW / 2;
  localparam int CTL_FALL = CTL_PS + PSW;
  localparam logic [DW-1:0] CTL_MASK = DW'((1 << (CTL_FALL + 1)) - 1);

  logic [DW-1:0]  ctrl_q;
  logic [CW-1:0]  rld_q;
  logic [HB-1:0]  shadow;
  logic [CW-1:0]  cnt, cap;
  logic           run, cap_mode, fall, started, count_en, tick, act_edge;
  logic [PSW-1:0] ps_sel;
  logic           wr_cnt_hi, wr_cnt_lo;

  always_comb begin
    run       = ctrl_q[CTL_RUN];
    cap_mode  = ctrl_q[CTL_CAP];
    ps_sel    = ctrl_q[CTL_PS +: PSW];
    fall      = ctrl_q[CTL_FALL];
    wr_cnt_hi = bus_wr && (bus_addr == AW'(A_CNT_HI));
    wr_cnt_lo = bus_wr && (bus_addr == AW'(A_CNT_LO));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      rld_q  <= '1;
    end else if (bus_wr) begin
      case (bus_addr)
        AW'(A_RLD_HI): rld_q[CW-1:HB] <= bus_wdata;
        AW'(A_RLD_LO): rld_q[HB-1:0]  <= bus_wdata;
        AW'(A_CTRL):   ctrl_q         <= bus_wdata & CTL_MASK;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      shadow <= '0;
    else if (bus_rd && run && (bus_addr == AW'(A_CNT_HI)))
      shadow <= cnt[HB-1:0];
  end

  always_comb begin
    case (bus_addr)
      AW'(A_CNT_HI): bus_rdata = cnt[CW-1:HB];
      AW'(A_CNT_LO): bus_rdata = run ? shadow : cnt[HB-1:0];
      AW'(A_RLD_HI): bus_rdata = rld_q[CW-1:HB];
      AW'(A_RLD_LO): bus_rdata = rld_q[HB-1:0];
      AW'(A_CTRL):   bus_rdata = ctrl_q;
      AW'(A_CAP_HI): bus_rdata = cap[CW-1:HB];
      AW'(A_CAP_LO): bus_rdata = cap[HB-1:0];
      default:       bus_rdata = '0;
    endcase
  end

  tmr16_prescaler #(.PSW(PSW)) u_ps (
    .clk(clk), .rst_n(rst_n), .run(count_en), .ps_sel(ps_sel), .tick(tick)
  );

  tmr16_edge_det #(.STAGES(SYNC)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin(tmr_in), .falling(fall), .act_edge(act_edge)
  );

  tmr16_core #(.CW(CW)) u_core (
    .clk(clk), .rst_n(rst_n), .run(run), .cap_mode(cap_mode), .tick(tick),
    .act_edge(act_edge), .wr_hi(wr_cnt_hi), .wr_lo(wr_cnt_lo),
    .wdata(bus_wdata), .reload(rld_q), .cnt_o(cnt), .cap_o(cap),
    .started_o(started), .count_en(count_en), .tout(tmr_out), .irq(tmr_irq)
  );
endmodule

// File: rtl/tmr16_chk.sv
module tmr16_chk #(
  parameter int CW = 16,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic          run,
  input logic          cap_mode,
  input logic          count_en,
  input logic          started,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] cap,
  input logic [CW/2-1:0] shadow,
  input logic          tout,
  input logic          irq
);
  logic [CW/2-1:0] cnt_lo;
  assign cnt_lo = cnt[CW/2-1:0];

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(count_en) && !$past(bus_wr)) |-> $stable(cnt)); // R2

  AST_SHADOW_SNAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_rd) && $past(run) && $past(bus_addr) == AW'(0)) |-> shadow == $past(cnt_lo)); // R3

  AST_RELOAD_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !$past(cap_mode)) |-> cnt == CW'(1)); // R7

  AST_TOGGLE_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tout) |-> irq); // R8

  AST_START_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(started) |-> !irq); // R9

  AST_CAPTURE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap) |-> irq); // R10
endmodule

bind tmr16_top tmr16_chk #(.CW(CW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .run(run), .cap_mode(cap_mode), .count_en(count_en), .started(started),
  .cnt(cnt), .cap(cap), .shadow(shadow), .tout(tmr_out), .irq(tmr_irq)
);

// File: tb/tmr16_top_tb.sv
module tmr16_top_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       tmr_in = 1'b0;
  logic       tmr_out, tmr_irq;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  int irq_seen = 0;
  bit done = 0;

  tmr16_top u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_in(tmr_in),
    .tmr_out(tmr_out), .tmr_irq(tmr_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rst_n && tmr_irq) irq_seen <= irq_seen + 1;

  function automatic int exp_period(int e, int n);
    return n << e;
  endfunction

  function automatic int exp_count(int base, int steps);
    return (base + steps) & 16'hFFFF;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d, output int edge_idx);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
    edge_idx = cyc;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] d, output int c);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    d = bus_rdata;
    c = cyc;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] d, d2;
    int e0, ew, ew2, c1, c2, base, e, nrl, last, prev_out, s1, s2, s3, irq0;
    void'($urandom(32'd20240611));

    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset values
    for (int a = 0; a < 7; a++) begin
      int ev;
      rd_reg(3'(a), d, c1);
      case (a)
        0: ev = 8'h00; 1: ev = 8'h01; 2: ev = 8'hFF; 3: ev = 8'hFF;
        default: ev = 8'h00;
      endcase
      chk($sformatf("R1 reg %0d", a), d, ev);
    end
    chk("R1 tmr_out", tmr_out, 0);
    chk("R1 tmr_irq", tmr_irq, 0);

    // R2 stopped: hold, live low read; R5 writes while stopped
    wr_reg(3'd0, 8'h12, ew);
    wr_reg(3'd1, 8'h34, ew);
    idle(5);
    rd_reg(3'd1, d, c1);
    chk("R2 live low while stopped", d, 8'h34);
    rd_reg(3'd0, d, c1);
    chk("R2 high held while stopped", d, 8'h12);

    // R6 R7 R8 continuous mode: random pairs plus one directed corner
    for (int t = 0; t < 7; t++) begin
      e   = (t == 6) ? 7 : int'($urandom % 4);
      nrl = (t == 6) ? 2 : 2 + int'($urandom % 20);
      wr_reg(3'd4, 8'h00, ew);
      wr_reg(3'd0, 8'h00, ew);
      wr_reg(3'd1, 8'h01, ew);
      wr_reg(3'd2, 8'h00, ew);
      wr_reg(3'd3, 8'(nrl), ew);
      prev_out = tmr_out;
      wr_reg(3'd4, 8'((e << 2) | 1), e0);
      last = e0;
      for (int k = 0; k < 3; k++) begin
        int guard = 0;
        while (!tmr_irq && guard < 40000) begin
          @(negedge clk); guard++;
        end
        chk($sformatf("R6 R7 period e=%0d n=%0d", e, nrl), cyc - last, exp_period(e, nrl));
        chk("R8 output toggles on reload", tmr_out, prev_out ^ 1);
        prev_out = tmr_out;
        last = cyc;
        @(negedge clk);
        chk("R8 irq single pulse", tmr_irq, 0);
      end
    end

    // R3 shadow coherence across a low-byte wrap, R4 reads do not disturb
    wr_reg(3'd4, 8'h00, ew);
    wr_reg(3'd2, 8'hFF, ew);
    wr_reg(3'd3, 8'hFF, ew);
    wr_reg(3'd0, 8'h00, ew);
    wr_reg(3'd1, 8'hFD, ew);
    base = 16'h00FD;
    wr_reg(3'd4, 8'h01, e0);
    rd_reg(3'd0, d, c1);
    chk("R3 high byte", d, exp_count(base, c1 - e0) >> 8);
    idle(4);
    rd_reg(3'd1, d2, c2);
    chk("R3 low byte from shadow", d2, exp_count(base, c1 - e0) & 8'hFF);
    idle(3);
    rd_reg(3'd0, d, c1);
    rd_reg(3'd1, d2, c2);
    chk("R4 count undisturbed by reads", {d, d2}, exp_count(base, c1 - e0));

    // R5 byte writes while running
    idle(2);
    wr_reg(3'd1, 8'h40, ew);
    base = (exp_count(16'h00FD, ew - 1 - e0) & 16'hFF00) | 16'h40;
    idle(3);
    rd_reg(3'd0, d, c1);
    rd_reg(3'd1, d2, c2);
    chk("R5 low byte write while running", {d, d2}, exp_count(base, c1 - ew));
    wr_reg(3'd0, 8'h30, ew2);
    base = 16'h3000 | (exp_count(base, ew2 - 1 - ew) & 16'h00FF);
    idle(2);
    rd_reg(3'd0, d, c1);
    rd_reg(3'd1, d2, c2);
    chk("R5 high byte write while running", {d, d2}, exp_count(base, c1 - ew2));

    // R9 R10 capture mode, rising edges
    wr_reg(3'd4, 8'h00, ew);
    wr_reg(3'd0, 8'h00, ew);
    wr_reg(3'd1, 8'h01, ew);
    wr_reg(3'd4, 8'h03, e0);
    idle(6);
    rd_reg(3'd0, d, c1);
    rd_reg(3'd1, d2, c2);
    chk("R9 no counting before start edge", {d, d2}, 16'h0001);
    irq0 = irq_seen;
    tmr_in = 1'b1; s1 = cyc;
    idle(10);
    tmr_in = 1'b0;
    idle(27);
    chk("R9 start edge raises no irq", irq_seen - irq0, 0);
    tmr_in = 1'b1; s2 = cyc;
    idle(6);
    chk("R10 capture irq", irq_seen - irq0, 1);
    rd_reg(3'd5, d, c1);
    rd_reg(3'd6, d2, c1);
    chk("R10 first capture value", {d, d2}, s2 - s1);
    idle(5);
    tmr_in = 1'b0;
    idle(14);
    tmr_in = 1'b1; s3 = cyc;
    idle(6);
    rd_reg(3'd5, d, c1);
    rd_reg(3'd6, d2, c1);
    chk("R10 second capture value", {d, d2}, s3 - s1);

    // R10 falling polarity (control bit 5)
    wr_reg(3'd4, 8'h00, ew);
    wr_reg(3'd1, 8'h01, ew);
    wr_reg(3'd4, 8'h23, e0);
    idle(4);
    irq0 = irq_seen;
    tmr_in = 1'b0; s1 = cyc;
    idle(15);
    tmr_in = 1'b1;
    idle(10);
    chk("R10 rising edge ignored in falling mode", irq_seen - irq0, 0);
    tmr_in = 1'b0; s2 = cyc;
    idle(6);
    rd_reg(3'd5, d, c1);
    rd_reg(3'd6, d2, c1);
    chk("R10 falling capture value", {d, d2}, s2 - s1);

    // R11 reload match in capture mode
    wr_reg(3'd4, 8'h00, ew);
    wr_reg(3'd1, 8'h01, ew);
    wr_reg(3'd2, 8'h00, ew);
    wr_reg(3'd3, 8'h06, ew);
    wr_reg(3'd4, 8'h03, e0);
    idle(4);
    prev_out = tmr_out;
    tmr_in = 1'b1; s1 = cyc;
    while (cyc < s1 + 8) @(negedge clk);
    chk("R11 no irq before reload", tmr_irq, 0);
    @(negedge clk);
    chk("R11 reload irq in capture mode", tmr_irq, 1);
    chk("R11 output toggles in capture mode", tmr_out, prev_out ^ 1);

    finish_run();
  end
endmodule